// File: doc/BRIEF.md
# Working-Register Execution Unit with Flag Validity

This unit is the data path of a small byte-wide sequencer. Each issued instruction carries an opcode class, an 8-bit operand (a constant or a byte the sequencer has already fetched from memory) and a 3-bit count field. The unit updates an 8-bit working register and the carry (C) and zero (Z) flags. It covers arithmetic, logic, compare, bit test, rotate and shift operations.

Each flag has its own validity bit. The bit records whether the previous issued instruction produced that flag. Conditional branches use the flag value and the validity bit together. A branch is reported as taken only when the tested flag came from the instruction just before it.

The branch decision and the signed offset are combinational on the issued instruction. The external sequencer can therefore redirect its program counter in the same cycle. The unit does not handle instruction fetch, the program counter or memory access.

Top module: `accu_exec_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, the working register, C, Z and both validity bits go to 0. br_taken stays 0 while op_valid is 0.
- R2: Add (code 3), add with carry (4), subtract (5) and subtract with borrow (6) write the 8-bit result modulo 256 to the working register. C is set as follows: the carry out for adds, and 1 when a borrow occurred for subtracts. The with-carry forms add C or subtract C. Z=1 exactly when the result is 0. Both flags are marked valid.
- R3: Compare (code 7) sets C and Z exactly as subtract would. It leaves the working register unchanged and marks both flags valid.
- R4: AND (8), OR (9) and XOR (10) write the result to the working register and set Z from it. They mark Z valid and C invalid, and leave the C value unchanged.
- R5: Bit test (11) selects a bit of the working register with the count field (0 to 7). It sets Z=1 when that bit is 0 and Z=0 when it is 1. The working register is unchanged. Z is marked valid and C invalid.
- R6: Circular rotate left (12) and right (13) rotate the register by the count. C receives the last bit that wrapped around: the new bit 0 for a left rotate, the new bit 7 for a right rotate. A count of 0 leaves the register and C unchanged. Z follows the register, and both flags are marked valid.
- R7: Rotate left (14) and right (15) through carry treat {C, register} as a 9-bit ring. They rotate it by the count in one cycle, equal to that many single-bit rotations. Z follows the register, and both flags are marked valid.
- R8: Shift left (16) and right (17) move in zeros by the count. C receives the last bit shifted out, and a count of 0 changes nothing. Z follows the register, and both flags are marked valid.
- R9: The conditional branches are: on C=0 (18), on C=1 (19), on Z=1 (20) and on Z=0 (21). Each is taken only when its condition holds and the tested flag's validity bit is 1. When taken, br_offset equals the operand; otherwise br_offset is 0.
- R10: The relative branch (22) is always taken. br_offset carries the operand as a signed offset from -128 to +127.
- R11: Load (1) copies the operand into the working register. Load, store (2), no-op (0) and every branch clear both validity bits and leave the flag values unchanged.
- R12: A cycle with op_valid low changes no state and reports no branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An instruction is issued this cycle |
| op_code | input | 5 | Opcode class (codes listed in the requirements) |
| operand | input | 8 | Constant, memory byte or branch offset |
| shift_cnt | input | 3 | Rotate/shift count or bit-test index |
| acc_out | output | 8 | Working register |
| c_flag | output | 1 | Carry / borrow flag |
| z_flag | output | 1 | Zero flag |
| c_valid | output | 1 | C was produced by the previous instruction |
| z_valid | output | 1 | Z was produced by the previous instruction |
| br_taken | output | 1 | Branch taken by the current instruction |
| br_offset | output | 8 | Signed branch offset, zero when not taken |

## Verification
The register, both flags and both validity bits are outputs. A wrong update to any of them is visible at the ports one clock after the faulty instruction. The per-cycle reference comparison catches it in that cycle. A validity bit that stays set too long, or is cleared too early, also shows up as a wrong br_taken on the next conditional branch, in the same cycle that branch is issued. Long random mixes put branches after every opcode class to expose exactly that. Directed steps cover counts 0, 1 and 7, borrow with and without incoming carry, and both offset extremes.

// File: rtl/accu_pkg.sv
// Shared opcode encoding for the working-register execution unit.
// Assumes a 5-bit opcode field; codes 23..31 behave as no-ops.
package accu_pkg;
    typedef enum logic [4:0] {
        OP_NOP = 5'd0,  OP_LD  = 5'd1,  OP_ST  = 5'd2,
        OP_ADD = 5'd3,  OP_ADC = 5'd4,  OP_SUB = 5'd5,  OP_SBC = 5'd6,
        OP_CMP = 5'd7,  OP_AND = 5'd8,  OP_OR  = 5'd9,  OP_XOR = 5'd10,
        OP_BIT = 5'd11, OP_RLC = 5'd12, OP_RRC = 5'd13, OP_ROL = 5'd14,
        OP_ROR = 5'd15, OP_SHL = 5'd16, OP_SHR = 5'd17, OP_BCC = 5'd18,
        OP_BCS = 5'd19, OP_BEQ = 5'd20, OP_BNE = 5'd21, OP_BRA = 5'd22
    } accu_op_e;
endpackage

// File: rtl/accu_arith.sv
// Arithmetic, logic, compare and bit-test datapath (purely combinational).
// Assumes the caller decides whether the result is written back; for
// compare and bit test the result is returned but must not be stored.
module accu_arith
    import accu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  accu_op_e          op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    input  logic              c_in,
    input  logic [CNT_W-1:0]  bit_sel,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              z_out
);
    logic [DATA_W:0] sum;
    logic [DATA_W:0] diff;
    logic            use_c;

    // Sum and difference with optional incoming carry/borrow.
    always_comb begin
        use_c = (op == OP_ADC || op == OP_SBC) ? c_in : 1'b0;
        sum   = {1'b0, acc} + {1'b0, operand} + {{DATA_W{1'b0}}, use_c};
        diff  = {1'b0, acc} - {1'b0, operand} - {{DATA_W{1'b0}}, use_c};
    end

    // Select result and flags per operation class.
    always_comb begin
        res   = acc;
        c_out = c_in;
        unique case (op)
            OP_ADD, OP_ADC:         begin res = sum[DATA_W-1:0];  c_out = sum[DATA_W];  end
            OP_SUB, OP_SBC, OP_CMP: begin res = diff[DATA_W-1:0]; c_out = diff[DATA_W]; end
            OP_AND: res = acc & operand;
            OP_OR:  res = acc | operand;
            OP_XOR: res = acc ^ operand;
            default: res = acc;
        endcase
        z_out = (op == OP_BIT) ? ~acc[bit_sel] : (res == '0);
    end
endmodule

// File: rtl/accu_shifter.sv
// Rotate and shift network: every count is precomputed in parallel and the
// requested one is selected, so a multi-bit move finishes in one cycle.
// Assumes a count of 0 means "no movement" for every variant.
module accu_shifter
    import accu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  accu_op_e          op,
    input  logic [DATA_W-1:0] acc,
    input  logic              c_in,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    logic [DATA_W-1:0] circ_l [DATA_W];
    logic [DATA_W-1:0] circ_r [DATA_W];
    logic [DATA_W:0]   thru_l [DATA_W];   // {C, register}
    logic [DATA_W:0]   thru_r [DATA_W];   // {C, register}
    logic [DATA_W:0]   lsh    [DATA_W];   // {C, register}
    logic [DATA_W:0]   rsh    [DATA_W];   // {register, C}
    logic [DATA_W:0]   ring;

    assign ring = {c_in, acc};

    for (genvar k = 0; k < DATA_W; k++) begin : g_cnt
        if (k == 0) begin : g_zero
            assign circ_l[k] = acc;
            assign circ_r[k] = acc;
            assign thru_l[k] = ring;
            assign thru_r[k] = ring;
            assign lsh[k]    = {c_in, acc};
            assign rsh[k]    = {acc, c_in};
        end else begin : g_move
            assign circ_l[k] = {acc[DATA_W-1-k:0], acc[DATA_W-1:DATA_W-k]};
            assign circ_r[k] = {acc[k-1:0], acc[DATA_W-1:k]};
            assign thru_l[k] = {ring[DATA_W-k:0], ring[DATA_W:DATA_W-k+1]};
            assign thru_r[k] = {ring[k-1:0], ring[DATA_W:k]};
            assign lsh[k]    = {acc[DATA_W-k:0], {k{1'b0}}};
            assign rsh[k]    = {{k{1'b0}}, acc[DATA_W-1:k-1]};
        end
    end

    // Pick the variant and the count-selected candidate.
    always_comb begin
        res   = acc;
        c_out = c_in;
        unique case (op)
            OP_RLC: begin
                res   = circ_l[count];
                c_out = (count == '0) ? c_in : circ_l[count][0];
            end
            OP_RRC: begin
                res   = circ_r[count];
                c_out = (count == '0) ? c_in : circ_r[count][DATA_W-1];
            end
            OP_ROL:  {c_out, res} = thru_l[count];
            OP_ROR:  {c_out, res} = thru_r[count];
            OP_SHL:  {c_out, res} = lsh[count];
            OP_SHR:  {res, c_out} = rsh[count];
            default: res = acc;
        endcase
    end
endmodule

// File: rtl/accu_branch.sv
// Conditional/unconditional branch resolution against the registered flags.
// Assumes flags and validity bits reflect the previous issued instruction.
module accu_branch
    import accu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  accu_op_e          op,
    input  logic              op_valid,
    input  logic              c_flag,
    input  logic              z_flag,
    input  logic              c_valid,
    input  logic              z_valid,
    input  logic [DATA_W-1:0] offset_in,
    output logic              taken,
    output logic [DATA_W-1:0] offset_out
);
    // Decide the branch and gate the offset.
    always_comb begin
        unique case (op)
            OP_BCC:  taken = c_valid & ~c_flag;
            OP_BCS:  taken = c_valid &  c_flag;
            OP_BEQ:  taken = z_valid &  z_flag;
            OP_BNE:  taken = z_valid & ~z_flag;
            OP_BRA:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
        taken      = taken & op_valid;
        offset_out = taken ? offset_in : '0;
    end
endmodule

// File: rtl/accu_exec_unit.sv
// Top of the working-register execution unit: holds the register, C and Z
// with per-flag validity, and merges the datapath results.
// Assumes at most one instruction per cycle, flagged by op_valid.
module accu_exec_unit
    import accu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  shift_cnt,
    output logic [DATA_W-1:0] acc_out,
    output logic              c_flag,
    output logic              z_flag,
    output logic              c_valid,
    output logic              z_valid,
    output logic              br_taken,
    output logic [DATA_W-1:0] br_offset
);
    accu_op_e          op;
    logic [DATA_W-1:0] acc_q, acc_d, ar_res, sh_res;
    logic              c_q, c_d, z_q, z_d, cv_q, cv_d, zv_q, zv_d;
    logic              ar_c, ar_z, sh_c;

    assign op = accu_op_e'(op_code);

    accu_arith #(.DATA_W(DATA_W)) u_arith (
        .op(op), .acc(acc_q), .operand(operand), .c_in(c_q),
        .bit_sel(shift_cnt), .res(ar_res), .c_out(ar_c), .z_out(ar_z)
    );

    accu_shifter #(.DATA_W(DATA_W)) u_shift (
        .op(op), .acc(acc_q), .c_in(c_q), .count(shift_cnt),
        .res(sh_res), .c_out(sh_c)
    );

    accu_branch #(.DATA_W(DATA_W)) u_branch (
        .op(op), .op_valid(op_valid), .c_flag(c_q), .z_flag(z_q),
        .c_valid(cv_q), .z_valid(zv_q), .offset_in(operand),
        .taken(br_taken), .offset_out(br_offset)
    );

    // Next-state selection for register, flags and validity bits.
    always_comb begin
        acc_d = acc_q;
        c_d   = c_q;
        z_d   = z_q;
        cv_d  = cv_q;
        zv_d  = zv_q;
        if (op_valid) begin
            unique case (op)
                OP_LD: begin
                    acc_d = operand;
                    cv_d  = 1'b0;
                    zv_d  = 1'b0;
                end
                OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                    acc_d = ar_res; c_d = ar_c; z_d = ar_z;
                    cv_d  = 1'b1;   zv_d = 1'b1;
                end
                OP_CMP: begin
                    c_d  = ar_c; z_d  = ar_z;
                    cv_d = 1'b1; zv_d = 1'b1;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    acc_d = ar_res; z_d = ar_z;
                    cv_d  = 1'b0;   zv_d = 1'b1;
                end
                OP_BIT: begin
                    z_d  = ar_z;
                    cv_d = 1'b0; zv_d = 1'b1;
                end
                OP_RLC, OP_RRC, OP_ROL, OP_ROR, OP_SHL, OP_SHR: begin
                    acc_d = sh_res; c_d = sh_c; z_d = (sh_res == '0);
                    cv_d  = 1'b1;   zv_d = 1'b1;
                end
                default: begin
                    cv_d = 1'b0;
                    zv_d = 1'b0;
                end
            endcase
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            c_q   <= 1'b0;
            z_q   <= 1'b0;
            cv_q  <= 1'b0;
            zv_q  <= 1'b0;
        end else begin
            acc_q <= acc_d;
            c_q   <= c_d;
            z_q   <= z_d;
            cv_q  <= cv_d;
            zv_q  <= zv_d;
        end
    end

    assign acc_out = acc_q;
    assign c_flag  = c_q;
    assign z_flag  = z_q;
    assign c_valid = cv_q;
    assign z_valid = zv_q;
endmodule

// File: rtl/accu_exec_checker.sv
// Protocol checker for accu_exec_unit, attached by bind.
// Assumes it observes only the unit's ports.
module accu_exec_checker
    import accu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        op_code,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] acc_out,
    input logic              c_flag,
    input logic              z_flag,
    input logic              c_valid,
    input logic              z_valid,
    input logic              br_taken,
    input logic [DATA_W-1:0] br_offset
);
    assert_c_branch_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && (op_code == OP_BCC || op_code == OP_BCS)) |-> c_valid);

    assert_z_branch_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && (op_code == OP_BEQ || op_code == OP_BNE)) |-> z_valid);

    assert_bra_always_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_BRA) |-> (br_taken && br_offset == operand));

    assert_cmp_keeps_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |=> ($stable(acc_out) && c_valid && z_valid));

    assert_logic_validity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
        |=> (z_valid && !c_valid && $stable(c_flag)));

    assert_arith_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_ADD || op_code == OP_ADC ||
                      op_code == OP_SUB || op_code == OP_SBC))
        |=> (z_flag == (acc_out == '0)));

    assert_load_clears_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LD) |=> (acc_out == $past(operand) && !c_valid && !z_valid));

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_out) && $stable(c_flag) && $stable(z_flag) &&
                       $stable(c_valid) && $stable(z_valid)));

    assert_idle_no_branch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !br_taken);
endmodule

bind accu_exec_unit accu_exec_checker #(.DATA_W(DATA_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .acc_out(acc_out), .c_flag(c_flag), .z_flag(z_flag),
    .c_valid(c_valid), .z_valid(z_valid), .br_taken(br_taken),
    .br_offset(br_offset)
);

// File: tb/accu_exec_unit_test.sv
// Self-checking bench: a behavioural model is stepped with every issued
// instruction and compared against all outputs each cycle.
module accu_exec_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] operand = '0;
    logic [2:0] shift_cnt = '0;
    logic [7:0] acc_out, br_offset;
    logic       c_flag, z_flag, c_valid, z_valid, br_taken;

    int n_chk = 0;
    int n_err = 0;
    int mw = 0, mc = 0, mz = 0, mcv = 0, mzv = 0;

    always #2 clk = ~clk;   // 250 MHz

    accu_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .shift_cnt(shift_cnt), .acc_out(acc_out),
        .c_flag(c_flag), .z_flag(z_flag), .c_valid(c_valid), .z_valid(z_valid),
        .br_taken(br_taken), .br_offset(br_offset)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op, input bit v);
        if (!v) return "R12";
        case (op)
            3, 4, 5, 6:             return "R2";
            7:                      return "R3";
            8, 9, 10:               return "R4";
            11:                     return "R5";
            12, 13:                 return "R6";
            14, 15:                 return "R7";
            16, 17:                 return "R8";
            18, 19, 20, 21:         return "R9";
            22:                     return "R10";
            default:                return "R11";
        endcase
    endfunction

    // Model update for one issued instruction.
    task automatic model(input int op, input int opd, input int cnt);
        int s, r, b;
        case (op)
            1: begin mw = opd; mcv = 0; mzv = 0; end
            3, 4: begin
                s = mw + opd + ((op == 4) ? mc : 0);
                mc = (s > 255); mw = s & 255; mz = (mw == 0); mcv = 1; mzv = 1;
            end
            5, 6, 7: begin
                s = mw - opd - ((op == 6) ? mc : 0);
                r = s & 255; mc = (s < 0); mz = (r == 0); mcv = 1; mzv = 1;
                if (op != 7) mw = r;
            end
            8, 9, 10: begin
                mw = (op == 8) ? (mw & opd) : (op == 9) ? (mw | opd) : (mw ^ opd);
                mz = (mw == 0); mzv = 1; mcv = 0;
            end
            11: begin mz = (((mw >> cnt) & 1) == 0); mzv = 1; mcv = 0; end
            12, 13, 14, 15, 16, 17: begin
                for (int i = 0; i < cnt; i++) begin
                    case (op)
                        12: begin b = mw >> 7; mw = ((mw << 1) | b) & 255; mc = mw & 1; end
                        13: begin b = mw & 1; mw = (mw >> 1) | (b << 7); mc = (mw >> 7) & 1; end
                        14: begin b = mw >> 7; mw = ((mw << 1) | mc) & 255; mc = b; end
                        15: begin b = mw & 1; mw = (mw >> 1) | (mc << 7); mc = b; end
                        16: begin mc = mw >> 7; mw = (mw << 1) & 255; end
                        default: begin mc = mw & 1; mw = mw >> 1; end
                    endcase
                end
                mz = (mw == 0); mcv = 1; mzv = 1;
            end
            default: begin mcv = 0; mzv = 0; end
        endcase
    endtask

    // Issue one instruction, check branch outputs before the edge and state after.
    task automatic step(input int op, input int opd, input int cnt, input bit v);
        int exp_t;
        string rq;
        rq = req_of(op, v);
        @(negedge clk);
        op_valid = v; op_code = 5'(op); operand = 8'(opd); shift_cnt = 3'(cnt);
        #1;
        exp_t = v && ((op == 18 && mcv && !mc) || (op == 19 && mcv && mc) ||
                      (op == 20 && mzv && mz) || (op == 21 && mzv && !mz) || op == 22);
        chk(rq, "br_taken", br_taken, exp_t);
        chk(rq, "br_offset", br_offset, exp_t ? opd : 0);
        if (v) model(op, opd, cnt);
        @(posedge clk);
        #1;
        chk(rq, "acc", acc_out, mw);
        chk(rq, "c", c_flag, mc);
        chk(rq, "z", z_flag, mz);
        chk(rq, "c_valid", c_valid, mcv);
        chk(rq, "z_valid", z_valid, mzv);
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "acc", acc_out, 0);
        chk("R1", "c", c_flag, 0);
        chk("R1", "z", z_flag, 0);
        chk("R1", "c_valid", c_valid, 0);
        chk("R1", "z_valid", z_valid, 0);
        chk("R1", "br_taken", br_taken, 0);
        rst_n = 1'b1;

        // R2 carry out to zero, then R9 branches needing fresh flags
        step(1, 8'h80, 0, 1);
        step(3, 8'h80, 0, 1);
        step(19, 5, 0, 1);        // BCS taken
        step(20, 9, 0, 1);        // BEQ after a branch: not taken (R9)
        step(1, 5, 0, 1);
        step(5, 6, 0, 1);         // borrow -> C=1
        step(6, 250, 0, 1);       // 255-250-1 = 4
        step(4, 255, 0, 1);       // 4+255+0
        step(7, 3, 0, 1);         // R3 compare
        step(21, 3, 0, 1);
        step(8, 8'h0F, 0, 1);     // R4 AND
        step(18, 7, 0, 1);        // BCC with C invalid: not taken
        step(9, 8'hA0, 0, 1);
        step(10, 8'hFF, 0, 1);
        step(11, 0, 0, 1);        // R5 bit test
        step(11, 0, 7, 1);
        step(20, 12, 0, 1);
        step(1, 8'h81, 0, 1);
        step(12, 0, 1, 1);        // R6
        step(13, 0, 7, 1);
        step(12, 0, 0, 1);
        step(14, 0, 3, 1);        // R7
        step(15, 0, 7, 1);
        step(16, 0, 7, 1);        // R8
        step(1, 8'hC3, 0, 1);
        step(17, 0, 2, 1);
        step(16, 0, 0, 1);
        step(22, 8'h80, 0, 1);    // R10 -128
        step(22, 8'h7F, 0, 1);    // R10 +127
        step(3, 1, 0, 1);
        step(19, 1, 0, 0);        // R12 idle
        step(2, 0, 0, 1);         // R11 store
        step(0, 0, 0, 1);

        for (int n = 0; n < 3000; n++) begin
            step(int'($urandom_range(0, 22)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 7)), ($urandom_range(0, 7) != 0));
        end

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule